// File: doc/BRIEF.md
# Bitwise Priority Bus Arbiter Node

This block is the contention engine of one node on a shared single-wire bus where there is no central arbiter. When a bus transfer finishes, every node that has traffic waiting puts its unique identifier on the wire, one bit per bit time, starting with the most significant bit. The wire is a wired-OR: a driven 1 overrides a 0. A node that drives a 0 but senses a 1 knows that a higher identifier is present. It stops driving and gives up for that round. After the last identifier bit, exactly one node is left, and it is the one whose identifier has the highest value.

Each node instance sees the bit-time strobe, a pulse that marks the end of the previous transfer, its own transmit request and identifier, and the sensed bus level. It returns its drive onto the wire and a won or lost result. The result stays in place until the next round begins, so the surrounding logic can send its payload or wait. A node that loses keeps its request and simply joins the next round. A node whose request arrives while a round is already running sits out that round.

Top module: `prio_arb_node`

## Requirements
- R1: After reset, drive_o, won_o and lost_o are 0. A round is already pending, so the first bit tick after reset starts a round with no transfer-end pulse.
- R2: A round starts on the first bit_tick_i after a pulse on xfer_end_i. A node joins only if req_i is high at that tick, and it samples id_i at that tick.
- R3: In bit time k of a round (k=0 begins at the starting tick), a participating node drives bit ID_W-1-k of its identifier. The wired-OR bus therefore shows the highest participating identifier, most significant bit first.
- R4: If a node senses bus_i=1 at a bit tick while driving 0, it sets lost_o and drives 0 for the rest of the round.
- R5: At the tick that ends the last identifier bit, the remaining node sets won_o. Exactly one node wins whenever any node takes part, and it is the one with the highest identifier.
- R6: won_o and lost_o are never both 1. Each holds until the next round starts, which clears it.
- R7: A node whose req_i rises after a round has started drives 0 and ends that round with neither won_o nor lost_o.
- R8: A node that lost and keeps req_i high joins the next round without any other action.
- R9: A xfer_end_i pulse that arrives while a round is running is ignored and does not start a further round.
- R10: drive_o changes only at bit ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle strobe that marks each bit-time boundary |
| xfer_end_i | input | 1 | Pulse: the bus transfer has ended and a new round may start |
| req_i | input | 1 | This node has traffic pending |
| id_i | input | ID_W | Unique identifier of the node (a higher value has higher priority) |
| bus_i | input | 1 | Sensed wired-OR bus level |
| drive_o | output | 1 | This node pulls the bus to 1 |
| won_o | output | 1 | This node won the last round |
| lost_o | output | 1 | This node withdrew in the last round |

## Verification
A shift register that is out of step, or a wrong bit counter, shows on the wire within the same round. The bus bit sequence then no longer matches the highest requesting identifier, so the bench records every bus bit and compares the full sequence. A withdrawal that comes too early or too late shows one bit time later, as two winners, no winner, or a wrong lost_o. A start condition that is latched wrongly shows as bus activity when no round should be running, or as a node that joins late. The bench watches the idle wire over a whole round length after a pulse that should have been ignored.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_WON  = 2'd1,
    RES_LOST = 2'd2
  } arb_res_e;
endpackage

// File: rtl/prio_arb_round.sv
module prio_arb_round #(
  parameter int ID_W = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic xfer_end_i,
  output logic start_o,
  output logic eval_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(ID_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ID_W - 1);

  logic             pend_q;
  logic             active_q;
  logic [CNT_W-1:0] idx_q;

  assign start_o = tick_i & pend_q & ~active_q;
  assign eval_o  = tick_i & active_q;
  assign last_o  = (idx_q == LAST_IDX);

  // bus is idle out of reset, so a round is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
    end else if (start_o) begin
      pend_q <= 1'b0;
    end else if (xfer_end_i && !active_q) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (eval_o) begin
      if (last_o) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_arb_shift.sv
module prio_arb_shift #(
  parameter int ID_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            shift_i,
  input  logic [ID_W-1:0] id_i,
  output logic            bit_o
);
  logic [ID_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q <= id_i;
    end else if (shift_i) begin
      sh_q <= {sh_q[ID_W-2:0], 1'b0};
    end
  end

  assign bit_o = sh_q[ID_W-1];
endmodule

// File: rtl/prio_arb_contend.sv
module prio_arb_contend
  import prio_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic eval_i,
  input  logic last_i,
  input  logic req_i,
  input  logic bit_i,
  input  logic bus_i,
  output logic drive_o,
  output logic won_o,
  output logic lost_o
);
  logic     in_q;
  arb_res_e res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      res_q <= RES_NONE;
    end else if (start_i) begin
      in_q  <= req_i;
      res_q <= RES_NONE;
    end else if (eval_i && in_q) begin
      if (!bit_i && bus_i) begin
        in_q  <= 1'b0;
        res_q <= RES_LOST;
      end else if (last_i) begin
        in_q  <= 1'b0;
        res_q <= RES_WON;
      end
    end
  end

  assign drive_o = in_q & bit_i;
  assign won_o   = (res_q == RES_WON);
  assign lost_o  = (res_q == RES_LOST);
endmodule

// File: rtl/prio_arb_node.sv
module prio_arb_node #(
  parameter int ID_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_tick_i,
  input  logic            xfer_end_i,
  input  logic            req_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            bus_i,
  output logic            drive_o,
  output logic            won_o,
  output logic            lost_o
);
  logic start, eval, last, cur_bit;

  prio_arb_round #(.ID_W(ID_W)) u_round (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (bit_tick_i),
    .xfer_end_i (xfer_end_i),
    .start_o    (start),
    .eval_o     (eval),
    .last_o     (last)
  );

  prio_arb_shift #(.ID_W(ID_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .shift_i (eval),
    .id_i    (id_i),
    .bit_o   (cur_bit)
  );

  prio_arb_contend u_contend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .eval_i  (eval),
    .last_i  (last),
    .req_i   (req_i),
    .bit_i   (cur_bit),
    .bus_i   (bus_i),
    .drive_o (drive_o),
    .won_o   (won_o),
    .lost_o  (lost_o)
  );
endmodule

// File: rtl/prio_arb_node_chk.sv
module prio_arb_node_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic bus_i,
  input logic drive_o,
  input logic won_o,
  input logic lost_o
);
  assert_lost_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_o) |-> $past(bit_tick_i && !drive_o && bus_i));

  assert_lost_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> !drive_o);

  assert_won_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(won_o) |-> $past(bit_tick_i));

  assert_won_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    won_o |-> !drive_o);

  assert_outcome_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(won_o && lost_o));

  assert_drive_on_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_tick_i) |-> $stable(drive_o));
endmodule

bind prio_arb_node prio_arb_node_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_tick_i (bit_tick_i),
  .bus_i      (bus_i),
  .drive_o    (drive_o),
  .won_o      (won_o),
  .lost_o     (lost_o)
);

// File: tb/prio_arb_node_bench.sv
module prio_arb_node_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int ID_W       = 11;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, xfer = 1'b0;
  logic [N-1:0] req = '0;
  logic [ID_W-1:0] ids [N];
  logic [N-1:0] drv, won, lost;
  logic bus;
  int tdiv = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV-1);
  end

  assign bus = |drv;

  for (genvar g = 0; g < N; g++) begin : g_node
    prio_arb_node #(.ID_W(ID_W)) u_prio_arb_node (
      .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .xfer_end_i(xfer),
      .req_i(req[g]), .id_i(ids[g]), .bus_i(bus),
      .drive_o(drv[g]), .won_o(won[g]), .lost_o(lost[g]));
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wait_tick;
    @(posedge clk);
    while (!tick) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [ID_W-1:0] max_id(input logic [N-1:0] p);
    logic [ID_W-1:0] m = '0;
    for (int n = 0; n < N; n++) if (p[n] && ids[n] > m) m = ids[n];
    return m;
  endfunction

  task automatic new_ids;
    for (int n = 0; n < N; n++) begin
      bit dup;
      do begin
        ids[n] = ID_W'($urandom);
        dup = 1'b0;
        for (int m = 0; m < n; m++) if (ids[m] == ids[n]) dup = 1'b1;
      end while (dup);
    end
  endtask

  // late >= 0: that node raises req at bit 3; mid: xfer pulse at bit 5
  task automatic run_round(input logic [N-1:0] r, input int late, input bit mid);
    logic [N-1:0] part = r;
    logic [ID_W-1:0] obs = '0, mx;
    logic [N-1:0] exp_w, hold;
    req = r; xfer = 1'b1;
    @(negedge clk) xfer = 1'b0;
    mx = max_id(part);
    for (int k = 0; k < ID_W; k++) begin
      wait_tick;
      obs[ID_W-1-k] = bus;
      @(negedge clk);
      chk("R10 drive stable mid bit", 32'(bus), 32'(obs[ID_W-1-k]));
      if (k == 3 && late >= 0) req[late] = 1'b1;
      if (k == 5 && mid) begin
        xfer = 1'b1;
        @(negedge clk) xfer = 1'b0;
      end
    end
    wait_tick;
    chk("R3 bus sequence", 32'(obs), 32'(mx));
    for (int n = 0; n < N; n++) begin
      exp_w[n] = part[n] && (ids[n] == mx);
      chk(late == n ? "R7 late won" : "R5 won", 32'(won[n]), 32'(exp_w[n]));
      chk(late == n ? "R7 late lost" : "R4 lost", 32'(lost[n]), 32'(part[n] && !exp_w[n]));
    end
    chk("R5 single winner", 32'($countones(won)), 32'(part != 0));
    if (mid) begin
      hold = won;
      for (int k = 0; k < ID_W + 2; k++) begin
        wait_tick;
        chk("R9 no extra round", 32'(bus), 32'd0);
      end
      chk("R6 R9 won held", 32'(won), 32'(hold));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    if (!done) $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    ids[0] = 11'h123; ids[1] = 11'h3a5; ids[2] = 11'h1ff; ids[3] = 11'h040;
    req = 4'b0100;
    repeat (3) @(negedge clk);
    chk("R1 drive reset", 32'(drv), 32'd0);
    chk("R1 won reset", 32'(won), 32'd0);
    chk("R1 lost reset", 32'(lost), 32'd0);
    rst_n = 1'b1;
    // first round starts without any xfer pulse
    for (int k = 0; k < ID_W + 2; k++) wait_tick;
    chk("R1 R2 pending round after reset", 32'(won), 32'b0100);

    // directed: priority and retry
    run_round(4'b0011, -1, 1'b0);
    chk("R8 loser lost", 32'(lost[0]), 32'd1);
    run_round(4'b0001, -1, 1'b0);
    chk("R8 retry wins", 32'(won[0]), 32'd1);
    // clear on next round start
    run_round(4'b0000, -1, 1'b0);
    chk("R6 cleared by new round", 32'(won | lost), 32'd0);
    // late joiner with higher id, plus ignored mid-round pulse
    run_round(4'b0001, 1, 1'b1);
    // ids differing only in lsb
    ids[0] = 11'h7fe; ids[1] = 11'h7ff; ids[2] = 11'h000; ids[3] = 11'h400;
    run_round(4'b1111, -1, 1'b0);
    run_round(4'b0101, -1, 1'b0);

    for (int i = 0; i < 24; i++) begin
      new_ids;
      run_round(N'($urandom), -1, (i % 6) == 0);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule